// File: doc/BRIEF.md
# Selectable Pin/Lock Edge Event Detector

This per-core unit watches one signal chosen from a bank of I/O pin lines or a bank of shared lock lines. It brings every candidate line through a synchronizer, picks the configured one, compares each new sample with the one before it, and decides whether the change matches the programmed edge polarity. A matching edge sets a sticky event flag. Software polls the flag later, so edges that happen while the core is busy with other work are kept.

The same detection drives two other consumers. The first is a one-cycle interrupt request pulse. The second is a wait engine. A core parks in the wait engine until an event arrives, and is released with fixed timing. A wait can carry an optional cycle limit, and when that limit runs out the release is marked as a timeout, which the core maps onto its carry flag. The unit is reconfigured by writing a single 9-bit word that holds the edge mode, the source bank and the line index.

Top module: `edge_event_unit`

## Requirements
- R1: After reset, `evt_flag`, `poll_data`, `irq`, `wait_done` and `wait_timeout` are all 0.
- R2: The configuration word is split as follows. Bits [8:7] hold the edge mode. Bit 6 chooses the bank: 0 for pins, 1 for locks. Bits [5:0] hold the line index. In the lock bank only index bits [3:0] are used, and bits [5:4] are ignored. Lines that are not selected never set the flag.
- R3: The edge mode codes are: 2'b01 detects a rising edge only, 2'b10 detects a falling edge only, and both 2'b00 and 2'b11 detect either edge.
- R4: Suppose the selected line changes just before clock edge k and the change matches the mode. Then `evt_flag` and `irq` both become 1 after edge k+2, and `irq` returns to 0 one cycle later.
- R5: Once set, `evt_flag` stays at 1 until it is polled, a configuration is written, or a wait consumes it.
- R6: In the cycle after a `poll_req` cycle, `poll_data` holds the flag value seen at that poll, and the flag is cleared. If an edge is detected in the same cycle as the poll, the flag is left set. At all other times `poll_data` is 0.
- R7: A configuration write clears `evt_flag`. Switching to a new source whose level differs from the old one does not create an edge.
- R8: While a wait is pending, an event produces a one-cycle `wait_done` pulse at the same time the flag would have been set, with `wait_timeout` equal to 0. That release absorbs the event, so the flag stays 0.
- R9: If a wait is requested while `evt_flag` is already 1, the wait is released with `wait_done`=1 after the following clock edge, and the flag is cleared.
- R10: Suppose the timeout is enabled with limit N≥1 and no event arrives. Then `wait_done` and `wait_timeout` are both 1 after the Nth clock edge that follows the edge which accepted `wait_req`. A limit of 0 behaves the same as a limit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load `cfg_word` |
| cfg_word | input | 9 | Edge mode, bank select, line index |
| pin_in | input | NPIN (64) | Asynchronous I/O pin lines |
| lock_in | input | NLOCK (16) | Shared lock lines |
| poll_req | input | 1 | Read and clear the event flag |
| wait_req | input | 1 | Start (or restart) a wait for the event |
| wait_tmo_en | input | 1 | Arm the timeout for this wait |
| wait_limit | input | TMO_W (16) | Timeout length in cycles |
| evt_flag | output | 1 | Sticky event flag |
| poll_data | output | 1 | Flag value returned by a poll |
| irq | output | 1 | Interrupt request pulse per detected edge |
| wait_done | output | 1 | Wait released (one-cycle pulse) |
| wait_timeout | output | 1 | The release was caused by the timeout |

## Verification
The bench builds the unit with its default parameters: 64 pins, 16 locks, a two-stage synchronizer and a 16-bit timeout counter. With these values the highest pin index (63) can be reached, and so can lock indices whose ignored upper bits are set. The three-edge latency is exact, which allows a poll to be placed in precisely the cycle where a new edge lands. The timeouts stay short, so limits of 0 and 5 can both be checked cycle by cycle.

// File: rtl/edge_event_pkg.sv
package edge_event_pkg;

  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    EM_ANY_A = 2'b00,
    EM_RISE  = 2'b01,
    EM_FALL  = 2'b10,
    EM_ANY_B = 2'b11
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e       mode;
    logic             use_lock;
    logic [IDX_W-1:0] index;
  } evt_cfg_t;

endpackage

// File: rtl/evt_src_sel.sv
module evt_src_sel
  import edge_event_pkg::*;
#(
  parameter int NPIN        = 64,
  parameter int NLOCK       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPIN-1:0]  pin_in,
  input  logic [NLOCK-1:0] lock_in,
  input  evt_cfg_t         cur_cfg,
  input  evt_cfg_t         new_cfg,
  output logic             cur_smp,
  output logic             new_smp
);

  localparam int LOCK_IW = (NLOCK > 1) ? $clog2(NLOCK) : 1;
  localparam int TOT     = NPIN + NLOCK;
  localparam logic [IDX_W:0] NPIN_L = (IDX_W+1)'(NPIN);

  logic [TOT-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= {lock_in, pin_in};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  logic [NPIN-1:0]  pins_s;
  logic [NLOCK-1:0] locks_s;
  assign pins_s  = stg[SYNC_STAGES-1][NPIN-1:0];
  assign locks_s = stg[SYNC_STAGES-1][TOT-1:NPIN];

  function automatic logic pick(evt_cfg_t c, logic [NPIN-1:0] pv, logic [NLOCK-1:0] lv);
    logic [LOCK_IW-1:0] li;
    li = c.index[LOCK_IW-1:0];
    if (c.use_lock)                    return lv[li];
    else if ({1'b0, c.index} < NPIN_L) return pv[c.index];
    else                               return 1'b0;
  endfunction

  assign cur_smp = pick(cur_cfg, pins_s, locks_s);
  assign new_smp = pick(new_cfg, pins_s, locks_s);

endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import edge_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  edge_mode_e mode,
  input  logic       smp,
  input  logic       new_smp,
  input  logic       cfg_we,
  input  logic       poll_req,
  input  logic       consume,
  output logic       hit,
  output logic       evt_flag,
  output logic       poll_data
);

  logic prev;
  logic rise, fall;

  assign rise = smp & ~prev;
  assign fall = ~smp & prev;

  always_comb begin
    unique case (mode)
      EM_RISE: hit = rise;
      EM_FALL: hit = fall;
      default: hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= 1'b0;
      evt_flag  <= 1'b0;
      poll_data <= 1'b0;
    end else begin
      prev      <= cfg_we ? new_smp : smp;
      poll_data <= poll_req ? evt_flag : 1'b0;
      if (cfg_we || consume) evt_flag <= 1'b0;
      else if (poll_req)     evt_flag <= hit;
      else                   evt_flag <= evt_flag | hit;
    end
  end

endmodule

// File: rtl/evt_wait_ctl.sv
module evt_wait_ctl #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_req,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] limit,
  input  logic             hit,
  input  logic             flag,
  output logic             busy,
  output logic             consume,
  output logic             wait_done,
  output logic             wait_timeout
);

  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] lim_q;
  logic             tmo_q;
  logic [TMO_W:0]   cnt_nxt;
  logic             expire;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign consume = busy & (hit | flag);
  assign expire  = busy & tmo_q & ~(hit | flag) & (cnt_nxt >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      cnt          <= '0;
      lim_q        <= '0;
      tmo_q        <= 1'b0;
      wait_done    <= 1'b0;
      wait_timeout <= 1'b0;
    end else begin
      wait_done    <= consume | expire;
      wait_timeout <= expire;
      if (wait_req) begin
        busy  <= 1'b1;
        cnt   <= '0;
        lim_q <= limit;
        tmo_q <= tmo_en;
      end else if (consume || expire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt_nxt[TMO_W-1:0];
      end
    end
  end

endmodule

// File: rtl/edge_event_unit.sv
module edge_event_unit
  import edge_event_pkg::*;
#(
  parameter int NPIN        = 64,
  parameter int NLOCK       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [8:0]       cfg_word,
  input  logic [NPIN-1:0]  pin_in,
  input  logic [NLOCK-1:0] lock_in,
  input  logic             poll_req,
  input  logic             wait_req,
  input  logic             wait_tmo_en,
  input  logic [TMO_W-1:0] wait_limit,
  output logic             evt_flag,
  output logic             poll_data,
  output logic             irq,
  output logic             wait_done,
  output logic             wait_timeout
);

  evt_cfg_t cfg_q;
  evt_cfg_t cfg_in;
  logic     cur_smp, new_smp, hit, consume, wait_busy;

  assign cfg_in = evt_cfg_t'(cfg_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_in;
      irq <= hit & ~cfg_we;
    end
  end

  evt_src_sel #(.NPIN(NPIN), .NLOCK(NLOCK), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .pin_in(pin_in), .lock_in(lock_in),
    .cur_cfg(cfg_q), .new_cfg(cfg_in), .cur_smp(cur_smp), .new_smp(new_smp)
  );

  evt_edge_det u_det (
    .clk(clk), .rst(rst), .mode(cfg_q.mode), .smp(cur_smp), .new_smp(new_smp),
    .cfg_we(cfg_we), .poll_req(poll_req), .consume(consume), .hit(hit),
    .evt_flag(evt_flag), .poll_data(poll_data)
  );

  evt_wait_ctl #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst(rst), .wait_req(wait_req), .tmo_en(wait_tmo_en),
    .limit(wait_limit), .hit(hit), .flag(evt_flag), .busy(wait_busy),
    .consume(consume), .wait_done(wait_done), .wait_timeout(wait_timeout)
  );

endmodule

// File: rtl/edge_event_unit_chk.sv
module edge_event_unit_chk (
  input logic clk,
  input logic rst,
  input logic cfg_we,
  input logic poll_req,
  input logic evt_flag,
  input logic poll_data,
  input logic irq,
  input logic wait_done,
  input logic wait_timeout,
  input logic wait_busy
);

  p_cfg_clears_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !evt_flag);

  p_poll_returns_r6: assert property (@(posedge clk) disable iff (rst)
    poll_req |=> (poll_data == $past(evt_flag)));

  p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && !poll_req && !cfg_we && !wait_busy) |=> evt_flag);

  p_irq_lands_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (evt_flag || wait_done));

  p_tmo_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    wait_timeout |-> wait_done);

  p_done_after_wait_r8: assert property (@(posedge clk) disable iff (rst)
    wait_done |-> $past(wait_busy));

endmodule

bind edge_event_unit edge_event_unit_chk u_chk (.*);

// File: tb/edge_event_unit_tb.sv
module edge_event_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPIN  = 64;
  localparam int NLOCK = 16;
  localparam int TMO_W = 16;

  // {cfg_word[8:0], level_before, level_after, expect_flag}
  localparam int NVEC = 10;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 6'd0,       1'b0, 1'b1, 1'b1},
    {2'b01, 1'b0, 6'd63,      1'b1, 1'b0, 1'b0},
    {2'b10, 1'b0, 6'd17,      1'b1, 1'b0, 1'b1},
    {2'b10, 1'b1, 6'd2,       1'b0, 1'b1, 1'b0},
    {2'b00, 1'b1, 6'd15,      1'b0, 1'b1, 1'b1},
    {2'b00, 1'b0, 6'd40,      1'b1, 1'b0, 1'b1},
    {2'b11, 1'b1, 6'b110101,  1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 6'd9,       1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 6'b100011,  1'b0, 1'b1, 1'b1},
    {2'b10, 1'b1, 6'd7,       1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [8:0] cfg_word;
  logic [NPIN-1:0] pin_in;
  logic [NLOCK-1:0] lock_in;
  logic poll_req, wait_req, wait_tmo_en;
  logic [TMO_W-1:0] wait_limit;
  logic evt_flag, poll_data, irq, wait_done, wait_timeout;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_event_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .pin_in(pin_in), .lock_in(lock_in), .poll_req(poll_req),
    .wait_req(wait_req), .wait_tmo_en(wait_tmo_en), .wait_limit(wait_limit),
    .evt_flag(evt_flag), .poll_data(poll_data), .irq(irq),
    .wait_done(wait_done), .wait_timeout(wait_timeout)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_src(logic lk, logic [5:0] idx, logic v);
    if (lk) lock_in[idx[3:0]] = v;
    else    pin_in[idx] = v;
  endtask

  task automatic write_cfg(logic [8:0] w);
    cfg_word = w;
    cfg_we   = 1'b1;
    step();
    cfg_we   = 1'b0;
  endtask

  task automatic do_poll();
    poll_req = 1'b1;
    step();
    poll_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_word = '0; pin_in = '0; lock_in = '0;
    poll_req = 0; wait_req = 0; wait_tmo_en = 0; wait_limit = '0;
    step(3);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 evt_flag", evt_flag, 1'b0);
    chk("R1 poll_data", poll_data, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wait_done", wait_done, 1'b0);
    chk("R1 wait_timeout", wait_timeout, 1'b0);

    // R2/R3 table of modes and sources
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] w;
      w = VEC[v][11:3];
      pin_in = '0; lock_in = '0;
      set_src(w[6], w[5:0], VEC[v][2]);
      step(4);
      write_cfg(w);
      set_src(w[6], w[5:0], VEC[v][1]);
      step(4);
      chk($sformatf("R3 R2 vec%0d", v), evt_flag, VEC[v][0]);
      do_poll();
    end

    // R2 unselected lines ignored: lock 5 via index with upper bits set
    pin_in = '0; lock_in = '0;
    step(4);
    write_cfg({2'b01, 1'b1, 6'b110101});
    pin_in[5] = 1'b1; pin_in[53] = 1'b1; lock_in[4] = 1'b1; lock_in[6] = 1'b1;
    step(5);
    chk("R2 unselected", evt_flag, 1'b0);
    lock_in[5] = 1'b1;
    step(4);
    chk("R2 selected lock5", evt_flag, 1'b1);
    do_poll();

    // R4 latency and irq pulse, R5 sticky
    pin_in = '0; lock_in = '0;
    step(4);
    write_cfg({2'b00, 1'b0, 6'd1});
    pin_in[1] = 1'b1;
    step(2);
    chk("R4 flag before edge k+2", evt_flag, 1'b0);
    chk("R4 irq before edge k+2", irq, 1'b0);
    step();
    chk("R4 flag at edge k+2", evt_flag, 1'b1);
    chk("R4 irq at edge k+2", irq, 1'b1);
    step();
    chk("R4 irq one cycle", irq, 1'b0);
    step(5);
    chk("R5 flag sticky", evt_flag, 1'b1);

    // R6 poll concurrent with a new edge
    pin_in[1] = 1'b0;
    step(2);
    poll_req = 1'b1;
    step();
    poll_req = 1'b0;
    chk("R6 poll_data returned", poll_data, 1'b1);
    chk("R6 concurrent edge keeps flag", evt_flag, 1'b1);
    do_poll();
    chk("R6 second poll data", poll_data, 1'b1);
    chk("R6 poll clears", evt_flag, 1'b0);
    step();
    chk("R6 poll_data idle", poll_data, 1'b0);

    // R7 cfg write clears flag, no false edge
    pin_in[2] = 1'b1;
    pin_in[1] = 1'b1;
    step(4);
    chk("R7 flag set first", evt_flag, 1'b1);
    write_cfg({2'b00, 1'b0, 6'd2});
    chk("R7 cfg clears", evt_flag, 1'b0);
    step(5);
    chk("R7 no false edge", evt_flag, 1'b0);

    // R8 wait released by an event
    write_cfg({2'b01, 1'b0, 6'd2});
    pin_in[2] = 1'b0;
    step(4);
    chk("R8 fall ignored in rise mode", evt_flag, 1'b0);
    wait_req = 1'b1; wait_tmo_en = 1'b0;
    step();
    wait_req = 1'b0;
    pin_in[2] = 1'b1;
    step(2);
    chk("R8 not yet released", wait_done, 1'b0);
    step();
    chk("R8 wait_done", wait_done, 1'b1);
    chk("R8 no timeout", wait_timeout, 1'b0);
    chk("R8 irq", irq, 1'b1);
    chk("R8 flag consumed", evt_flag, 1'b0);
    step();
    chk("R8 done one cycle", wait_done, 1'b0);

    // R9 pending flag releases at once
    pin_in[2] = 1'b0;
    step(4);
    pin_in[2] = 1'b1;
    step(4);
    chk("R9 flag pending", evt_flag, 1'b1);
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    chk("R9 not at accept edge", wait_done, 1'b0);
    step();
    chk("R9 wait_done", wait_done, 1'b1);
    chk("R9 flag cleared", evt_flag, 1'b0);

    // R10 timeout limit 5
    step(2);
    wait_req = 1'b1; wait_tmo_en = 1'b1; wait_limit = 16'd5;
    step();
    wait_req = 1'b0;
    step(4);
    chk("R10 before limit", wait_done, 1'b0);
    step();
    chk("R10 done at limit", wait_done, 1'b1);
    chk("R10 timeout at limit", wait_timeout, 1'b1);
    step();
    chk("R10 timeout one cycle", wait_timeout, 1'b0);

    // R10 limit 0 acts as 1
    wait_req = 1'b1; wait_limit = 16'd0;
    step();
    wait_req = 1'b0;
    step();
    chk("R10 limit0 done", wait_done, 1'b1);
    chk("R10 limit0 timeout", wait_timeout, 1'b1);
    wait_tmo_en = 1'b0;
    step(2);

    finish_run();
  end

endmodule